// File: doc/BRIEF.md
# USB Endpoint Transaction Interrupt Generator

This block turns the transaction events reported by a USB serial interface engine into one interrupt flag per endpoint. There are five endpoints. A flag is raised only when a transaction completes properly. For an IN transfer, the device must have sent its final data packet and the host must have acknowledged it. For an OUT transfer, the host must have delivered its final data packet and the device must have acknowledged it. An IN transaction that gets no acknowledge from the host leaves its endpoint untouched.

The engine reports events on a single strobed bus. Each event carries a 3-bit code, an endpoint number and a last-packet bit. A shared tracker state machine follows one transaction at a time through these states:
- `S_IDLE`: waits for a token.
- `S_IN_DATA`: an IN token was seen; waits for the data the device sends.
- `S_OUT_DATA`: an OUT token was seen; waits for the data the host sends.
- `S_IN_HS`: the final IN data was sent; waits for the host's ACK.
- `S_OUT_HS`: the final OUT data was received; waits for the device's ACK.
- `S_DRAIN`: the data packet was not the final one; waits for its handshake without raising anything.

The tracker moves between these states as follows:
- A valid IN or OUT token moves it from any state to `S_IN_DATA` or `S_OUT_DATA` and latches the endpoint.
- A token naming an endpoint outside the implemented range sends it to `S_IDLE`.
- In a data state, a matching data event moves it to a handshake state if the last bit is set, or to `S_DRAIN` if it is clear. Any other event sends it to `S_IDLE`.
- In a handshake state, the correct ACK raises a one-cycle fire for the latched endpoint. Every event leaves a handshake state for `S_IDLE`.
- In `S_DRAIN`, any non-token event returns it to `S_IDLE`.

Each endpoint keeps a sticky pending flag, gated by that endpoint's enable bit. Firmware clears flags by writing ones. The combined request is the OR of the pending flags whose endpoints are enabled.

Top module: `usb_ep_irq_gen`

## Requirements
- R1: After reset, every bit of `ep_pending` is 0 and `irq` is 0.
- R2: The IN sequence sets `ep_pending[n]` on the clock edge that samples the ACK. The sequence is: code 1 (IN token, endpoint n), then code 2 (device data sent) with `ev_last`=1, then code 4 (ACK from host).
- R3: The OUT sequence sets `ep_pending[n]` on the clock edge that samples the ACK. The sequence is: code 0 (OUT token, endpoint n), then code 3 (host data received) with `ev_last`=1, then code 5 (ACK from device).
- R4: In a handshake wait, code 6 (abort: NAK, STALL or timeout), code 7, or an ACK from the wrong side (code 5 after IN data, code 4 after OUT data) sets nothing and returns the tracker to idle.
- R5: A data event with `ev_last`=0 sets nothing, even when the matching ACK follows it.
- R6: A completed transaction on an endpoint whose `ep_enable` bit is 0 sets nothing. Enabling that endpoint afterwards still shows the flag as 0.
- R7: A cycle with `clr_we`=1 clears exactly the pending bits whose `clr_mask` bit is 1. Other bits keep their values.
- R8: When a set and a clear of the same endpoint fall in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when some endpoint has both its pending bit and its enable bit at 1. Clearing an enable bit masks `irq` but keeps the pending bit.
- R10: Tokens that name endpoint 5, 6 or 7 are ignored, and no flag is set by the transaction that follows.
- R11: A new valid token abandons any transaction in progress. Only the newest transaction can raise a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_code | input | 3 | Event code (0 OUT token, 1 IN token, 2 data sent, 3 data received, 4 host ACK, 5 device ACK, 6 abort, 7 reserved) |
| ev_ep | input | 3 | Endpoint number carried by token events |
| ev_last | input | 1 | Data event is the final packet of its transaction |
| ep_enable | input | 5 | Per-endpoint interrupt enable |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_mask | input | 5 | Write-one-to-clear pattern for pending flags |
| ep_pending | output | 5 | Per-endpoint pending flags |
| irq | output | 1 | Combined interrupt request |

## Verification
Some properties can be checked on every cycle, and the assertions cover them:
- A pending flag never rises unless an ACK event was sampled.
- A flag never falls without a matching clear write.
- A fire into an enabled endpoint always lands, even against a clear in the same cycle.
- A disabled, idle endpoint stays quiet.
- `irq` stays low when no enabled flag is pending.
- A token for an unimplemented endpoint is never followed by a fire.

Other behaviours depend on whole event sequences, and only the bench's directed scenarios can show them:
- The exact ordering that makes a transaction qualify.
- The rejection of aborted, wrong-source and non-final transactions.
- Restart on a new token.
- Selective clearing.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

    typedef enum logic [2:0] {
        EV_TOK_OUT  = 3'd0,
        EV_TOK_IN   = 3'd1,
        EV_DATA_TX  = 3'd2,
        EV_DATA_RX  = 3'd3,
        EV_ACK_HOST = 3'd4,
        EV_ACK_DEV  = 3'd5,
        EV_ABORT    = 3'd6,
        EV_RSVD     = 3'd7
    } ev_code_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_IN_DATA  = 3'd1,
        S_OUT_DATA = 3'd2,
        S_IN_HS    = 3'd3,
        S_OUT_HS   = 3'd4,
        S_DRAIN    = 3'd5
    } txn_state_e;

endpackage

// File: rtl/usb_ep_txn_fsm.sv
module usb_ep_txn_fsm
    import usb_ep_irq_pkg::*;
#(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [2:0]        ev_code,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_last,
    output logic [NUM_EP-1:0] fire_vec
);

    txn_state_e      state_q, state_d;
    logic [EP_W-1:0] ep_q, ep_d;
    logic            fire_ok;
    ev_code_e        code;
    logic            is_token;
    logic            ep_ok;

    assign code     = ev_code_e'(ev_code);
    assign is_token = (code == EV_TOK_IN) || (code == EV_TOK_OUT);
    assign ep_ok    = (int'(ev_ep) < NUM_EP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ep_q    <= '0;
        end else begin
            state_q <= state_d;
            ep_q    <= ep_d;
        end
    end

    // transition logic
    always_comb begin
        state_d = state_q;
        ep_d    = ep_q;
        fire_ok = 1'b0;
        if (ev_valid) begin
            if (is_token) begin
                if (ep_ok) begin
                    state_d = (code == EV_TOK_IN) ? S_IN_DATA : S_OUT_DATA;
                    ep_d    = ev_ep;
                end else begin
                    state_d = S_IDLE;
                end
            end else begin
                unique case (state_q)
                    S_IDLE: state_d = S_IDLE;
                    S_IN_DATA: begin
                        if (code == EV_DATA_TX)
                            state_d = ev_last ? S_IN_HS : S_DRAIN;
                        else
                            state_d = S_IDLE;
                    end
                    S_OUT_DATA: begin
                        if (code == EV_DATA_RX)
                            state_d = ev_last ? S_OUT_HS : S_DRAIN;
                        else
                            state_d = S_IDLE;
                    end
                    S_IN_HS: begin
                        fire_ok = (code == EV_ACK_HOST);
                        state_d = S_IDLE;
                    end
                    S_OUT_HS: begin
                        fire_ok = (code == EV_ACK_DEV);
                        state_d = S_IDLE;
                    end
                    S_DRAIN: state_d = S_IDLE;
                    default: state_d = S_IDLE;
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        for (int i = 0; i < NUM_EP; i++) begin
            fire_vec[i] = fire_ok && (ep_q == EP_W'(i));
        end
    end

endmodule

// File: rtl/usb_ep_flag_cell.sv
module usb_ep_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i && en_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/usb_ep_irq_merge.sv
module usb_ep_irq_merge #(
    parameter int NUM_EP = 5
) (
    input  logic [NUM_EP-1:0] pending,
    input  logic [NUM_EP-1:0] enable,
    output logic              irq
);

    assign irq = |(pending & enable);

endmodule

// File: rtl/usb_ep_irq_gen.sv
module usb_ep_irq_gen #(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [2:0]        ev_code,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_last,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic              clr_we,
    input  logic [NUM_EP-1:0] clr_mask,
    output logic [NUM_EP-1:0] ep_pending,
    output logic              irq
);

    logic [NUM_EP-1:0] fire_vec;

    usb_ep_txn_fsm #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .ev_ep    (ev_ep),
        .ev_last  (ev_last),
        .fire_vec (fire_vec)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_flag
        usb_ep_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (fire_vec[g]),
            .en_i   (ep_enable[g]),
            .clr_i  (clr_we && clr_mask[g]),
            .flag_o (ep_pending[g])
        );
    end

    usb_ep_irq_merge #(.NUM_EP(NUM_EP)) u_merge (
        .pending (ep_pending),
        .enable  (ep_enable),
        .irq     (irq)
    );

endmodule

// File: rtl/usb_ep_irq_chk.sv
module usb_ep_irq_chk #(
    parameter int NUM_EP = 5,
    parameter int EP_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [2:0]        ev_code,
    input logic [EP_W-1:0]   ev_ep,
    input logic [NUM_EP-1:0] ep_enable,
    input logic              clr_we,
    input logic [NUM_EP-1:0] clr_mask,
    input logic [NUM_EP-1:0] ep_pending,
    input logic              irq,
    input logic [NUM_EP-1:0] fire_vec
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        // R2 R3: a flag rises only after a sampled ACK event
        p_rise_needs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ep_pending[g]) |-> $past(ev_valid && (ev_code == 3'd4 || ev_code == 3'd5)));
        p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ep_pending[g]) |-> $past(clr_we && clr_mask[g]));
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_vec[g] && ep_enable[g]) |=> ep_pending[g]);
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!ep_enable[g] && !ep_pending[g]) |=> !ep_pending[g]);
    end

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ep_pending & ep_enable) == '0) |-> !irq);

    p_bad_ep_no_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_code == 3'd0 || ev_code == 3'd1) && int'(ev_ep) >= NUM_EP)
        |=> (fire_vec == '0));

    p_fire_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec));

endmodule

bind usb_ep_irq_gen usb_ep_irq_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_code    (ev_code),
    .ev_ep      (ev_ep),
    .ep_enable  (ep_enable),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .ep_pending (ep_pending),
    .irq        (irq),
    .fire_vec   (fire_vec)
);

// File: tb/usb_ep_irq_gen_test.sv
`timescale 1ns/1ps
module usb_ep_irq_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_code = '0;
    logic [2:0] ev_ep = '0;
    logic       ev_last = 1'b0;
    logic [4:0] ep_enable = 5'h1f;
    logic       clr_we = 1'b0;
    logic [4:0] clr_mask = '0;
    logic [4:0] ep_pending;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usb_ep_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_ep(ev_ep), .ev_last(ev_last), .ep_enable(ep_enable),
        .clr_we(clr_we), .clr_mask(clr_mask), .ep_pending(ep_pending), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one event per cycle, optionally with a clear write in the same cycle
    task automatic put(input logic [2:0] c, input logic [2:0] ep, input logic last,
                       input logic clr, input logic [4:0] mask);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = c; ev_ep = ep; ev_last = last;
        clr_we = clr; clr_mask = mask;
        @(negedge clk);
        ev_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic ev(input logic [2:0] c, input logic [2:0] ep, input logic last);
        put(c, ep, last, 1'b0, 5'h0);
    endtask

    task automatic clear(input logic [4:0] mask);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = mask;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset;
        check("R1 pending", ep_pending, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_in_ok;
        ev(3'd1, 3'd2, 0); ev(3'd2, 3'd0, 1);
        check("R2 before ack", ep_pending, 0);
        ev(3'd4, 3'd0, 0);
        check("R2 pending", ep_pending, 5'h04);
        check("R9 irq on", irq, 1);
        clear(5'h1f);
    endtask

    task automatic t_out_ok;
        ev(3'd0, 3'd0, 0); ev(3'd3, 3'd0, 1); ev(3'd5, 3'd0, 0);
        check("R3 pending", ep_pending, 5'h01);
    endtask

    task automatic t_bad_handshake;
        ev(3'd1, 3'd1, 0); ev(3'd2, 3'd0, 1); ev(3'd6, 3'd0, 0);
        check("R4 abort", ep_pending, 5'h01);
        ev(3'd1, 3'd1, 0); ev(3'd2, 3'd0, 1); ev(3'd5, 3'd0, 0);
        check("R4 wrong source IN", ep_pending, 5'h01);
        ev(3'd0, 3'd1, 0); ev(3'd3, 3'd0, 1); ev(3'd4, 3'd0, 0);
        check("R4 wrong source OUT", ep_pending, 5'h01);
        ev(3'd1, 3'd1, 0); ev(3'd2, 3'd0, 1); ev(3'd6, 3'd0, 0); ev(3'd4, 3'd0, 0);
        check("R4 late ack", ep_pending, 5'h01);
    endtask

    task automatic t_not_last;
        ev(3'd1, 3'd3, 0); ev(3'd2, 3'd0, 0); ev(3'd4, 3'd0, 0);
        check("R5 non-final", ep_pending, 5'h01);
    endtask

    task automatic t_disabled;
        @(negedge clk); ep_enable = 5'h1f & ~5'h08;
        ev(3'd0, 3'd3, 0); ev(3'd3, 3'd0, 1); ev(3'd5, 3'd0, 0);
        check("R6 disabled", ep_pending, 5'h01);
        @(negedge clk); ep_enable = 5'h1f;
        @(negedge clk);
        check("R6 after enable", ep_pending, 5'h01);
    endtask

    task automatic t_collision;
        ev(3'd0, 3'd0, 0); ev(3'd3, 3'd0, 1);
        put(3'd5, 3'd0, 0, 1'b1, 5'h01);
        check("R8 set wins", ep_pending, 5'h01);
    endtask

    task automatic t_clear;
        ev(3'd1, 3'd4, 0); ev(3'd2, 3'd0, 1); ev(3'd4, 3'd0, 0);
        check("R7 setup", ep_pending, 5'h11);
        clear(5'h01);
        check("R7 selective", ep_pending, 5'h10);
    endtask

    task automatic t_mask;
        @(negedge clk); ep_enable = 5'h0f;
        @(negedge clk);
        check("R9 masked irq", irq, 0);
        check("R9 kept pending", ep_pending, 5'h10);
        @(negedge clk); ep_enable = 5'h1f;
        @(negedge clk);
        check("R9 unmasked irq", irq, 1);
        clear(5'h10);
        check("R9 irq off", irq, 0);
    endtask

    task automatic t_bad_ep;
        for (int e = 5; e < 8; e++) begin
            ev(3'd1, 3'(e), 0); ev(3'd2, 3'd0, 1); ev(3'd4, 3'd0, 0);
        end
        ev(3'd0, 3'd7, 0); ev(3'd3, 3'd0, 1); ev(3'd5, 3'd0, 0);
        check("R10 out of range", ep_pending, 0);
    endtask

    task automatic t_restart;
        ev(3'd1, 3'd1, 0); ev(3'd2, 3'd0, 1);
        ev(3'd0, 3'd4, 0); ev(3'd3, 3'd0, 1); ev(3'd5, 3'd0, 0);
        check("R11 restart", ep_pending, 5'h10);
        clear(5'h1f);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_ok();
        t_out_ok();
        t_bad_handshake();
        t_not_last();
        t_disabled();
        t_collision();
        t_clear();
        t_mask();
        t_bad_ep();
        t_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule